// File: doc/BRIEF.md
# Keyed Configuration Data Port

This block gives a host a table of small configuration items that it reaches through two ports. A 16-bit selector write picks an item by key and rewinds a byte cursor to the start of the item. A byte-wide data port then walks the item, one byte per access. Reads take bytes out. Writes put bytes in when the key asks for write access. Items sit in two banks, a generic bank and an architecture-local bank. Each item has a fixed length and preloaded byte storage. When a host fills a writable item completely, the block raises a one-cycle completion pulse that names the item and rewinds the cursor.

Reads follow valid/ready on both sides. A request on `rd_valid` is accepted in a cycle where `rd_ready` is high. `rd_ready` is high whenever the response register is empty or is being drained that cycle (`out_ready` high). A response stays on `out_data`, unchanged, until it is taken with `out_ready`. A request that is not accepted has no effect. Byte writes on `wr_valid` are never stalled. A write is dropped in any cycle where `rd_valid` is high, because the read owns the data port that cycle. Selector writes are plain strobes that are always taken.

Top module: `cfgp_port`

## Requirements
- R1: A selector write (`sel_wr`) loads the current key from `sel_key` and sets the byte offset to zero.
- R2: If `sel_key[13:0]` is 16 or more, the current key becomes the invalid value 0xFFFF.
- R3: Key bit 15 selects the architecture-local bank (bank 1). Bit 15 clear selects the generic bank (bank 0). The entry number is `key[3:0]`.
- R4: An accepted read with a valid key and offset below the item length returns the byte at the offset one cycle later on `out_data` with `out_valid`, then advances the offset by one.
- R5: An accepted read returns 0x00 and leaves the offset unchanged when any of these holds: the key is invalid, the item length is zero, or the offset is at or beyond the length.
- R6: A byte write stores `wr_data` at the offset and advances the offset only when all of these hold: the key is valid, key bit 14 (write access) is set, and the offset is below the length. Any other write changes nothing.
- R7: A write that brings the offset up to the item length raises `done_pulse` for exactly the next cycle. `done_bank` and `done_entry` name the item, and the offset returns to zero.
- R8: After reset the block behaves as if key 0 had been selected: offset 0, no response pending, no pulse.
- R9: Reset preloads the items; multi-byte numbers are stored least-significant byte first. Bank 0 entry 0 is "CFGP" (0x43 0x46 0x47 0x50, length 4). Entry 1 holds 0x1234 (length 2). Entry 2 holds 0xA1B2C3D4 (length 4). Entry 3 holds three zero bytes. Entry 4 holds the bytes 0x40+i for i = 0..15 (length 16). Bank 1 entry 0 holds 0xBEEF (length 2). Bank 1 entry 1 holds five zero bytes. Every other item has length zero.
- R10: When a selector write and a data access fall in the same cycle, the selector write takes effect first. The access uses the new key at offset zero.
- R11: When `rd_valid` and `wr_valid` are both high in a cycle, the write is dropped and the read proceeds if accepted.
- R12: While `out_valid` is high and `out_ready` is low, `rd_ready` is low and `out_data` holds. A read request in such a cycle is not performed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_wr | input | 1 | Selector write strobe |
| sel_key | input | 16 | Key written to the selector |
| rd_valid | input | 1 | Data read request |
| rd_ready | output | 1 | Read request can be accepted |
| wr_valid | input | 1 | Data byte write |
| wr_data | input | 8 | Byte to write |
| out_valid | output | 1 | Read response valid |
| out_data | output | 8 | Read response byte |
| out_ready | input | 1 | Host takes the read response |
| done_pulse | output | 1 | One-cycle completion pulse of a filled item |
| done_bank | output | 1 | Bank of the completed item |
| done_entry | output | 4 | Entry of the completed item |

## Verification
A selector write can fall in the same cycle as a data read or a data write. In that case the access must already see the new key at offset zero. The bench provokes this with directed select-plus-read and select-plus-write steps, and with random steps that raise `sel_wr` together with an access. It judges the result by the returned byte and by the bytes read back later, both compared with a bench model that applies the selector first. Read and write can also collide in one cycle. Such cycles are judged by the rule that the write leaves no trace in the item.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int KEY_W = 16;
  localparam int LEN_W = 16;
  localparam int IDX_FIELD_W = 14;
  localparam int WCH_BIT = 14;
  localparam int ARCH_BIT = 15;
  localparam logic [KEY_W-1:0] KEY_INVALID = 16'hFFFF;

  function automatic logic [LEN_W-1:0] item_len(input logic bank, input int unsigned entry);
    if (!bank) begin
      case (entry)
        0: return 16'd4;
        1: return 16'd2;
        2: return 16'd4;
        3: return 16'd3;
        4: return 16'd16;
        default: return 16'd0;
      endcase
    end
    case (entry)
      0: return 16'd2;
      1: return 16'd5;
      default: return 16'd0;
    endcase
  endfunction

  function automatic logic [7:0] item_init(input logic bank, input int unsigned entry,
                                           input int unsigned idx);
    logic [31:0] w;
    w = 32'h0;
    if (!bank) begin
      case (entry)
        0: w = 32'h5047_4643 >> (8 * idx);
        1: w = 32'h0000_1234 >> (8 * idx);
        2: w = 32'hA1B2_C3D4 >> (8 * idx);
        4: w = 32'h40 + idx;
        default: w = 32'h0;
      endcase
    end else if (entry == 0) begin
      w = 32'h0000_BEEF >> (8 * idx);
    end
    if (idx > 3 && entry != 4) w = 32'h0;
    return w[7:0];
  endfunction
endpackage

// File: rtl/cfgp_key_decode.sv
module cfgp_key_decode #(
  parameter int ENTRIES = 16
) (
  input  logic [cfgp_pkg::KEY_W-1:0] key_in,
  output logic [cfgp_pkg::KEY_W-1:0] key_out
);
  import cfgp_pkg::*;
  logic idx_ok;

  always_comb begin
    idx_ok  = key_in[IDX_FIELD_W-1:0] < IDX_FIELD_W'(ENTRIES);
    key_out = idx_ok ? key_in : KEY_INVALID;
  end
endmodule

// File: rtl/cfgp_item_store.sv
module cfgp_item_store #(
  parameter int ENTRIES = 16,
  parameter int MAX_LEN = 16,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int OFF_IDX_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bank,
  input  logic [IDX_W-1:0]            entry,
  input  logic [OFF_IDX_W-1:0]        off,
  input  logic                        wr_en,
  input  logic [7:0]                  wr_byte,
  output logic [7:0]                  rd_byte,
  output logic [cfgp_pkg::LEN_W-1:0]  len
);
  import cfgp_pkg::*;
  localparam int BANKS = 2;

  logic [7:0] mem [BANKS][ENTRIES][MAX_LEN];
  logic [LEN_W-1:0] raw_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < BANKS; b++)
        for (int e = 0; e < ENTRIES; e++)
          for (int i = 0; i < MAX_LEN; i++)
            mem[b][e][i] <= item_init(b == 1, e, i);
    end else if (wr_en) begin
      mem[bank][entry][off] <= wr_byte;
    end
  end

  always_comb begin
    raw_len = item_len(bank, int'(entry));
    len     = (raw_len > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : raw_len;
    rd_byte = mem[bank][entry][off];
  end
endmodule

// File: rtl/cfgp_seq.sv
module cfgp_seq #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sel_wr,
  input  logic [cfgp_pkg::KEY_W-1:0]  norm_key,
  input  logic                        rd_valid,
  output logic                        rd_ready,
  input  logic                        wr_valid,
  input  logic [7:0]                  wr_data,
  output logic                        out_valid,
  output logic [7:0]                  out_data,
  input  logic                        out_ready,
  input  logic [7:0]                  rd_byte,
  input  logic [cfgp_pkg::LEN_W-1:0]  item_len,
  output logic [cfgp_pkg::KEY_W-1:0]  eff_key,
  output logic [cfgp_pkg::LEN_W-1:0]  eff_off,
  output logic                        wr_en,
  output logic [7:0]                  wr_byte,
  output logic                        done_pulse,
  output logic                        done_bank,
  output logic [IDX_W-1:0]            done_entry,
  output logic [cfgp_pkg::KEY_W-1:0]  cur_key,
  output logic [cfgp_pkg::LEN_W-1:0]  cur_off
);
  import cfgp_pkg::*;

  logic             key_ok, in_range, rd_fire, wr_take, fill_end;
  logic [LEN_W-1:0] off_inc, next_off;

  always_comb begin
    eff_key  = sel_wr ? norm_key : cur_key;
    eff_off  = sel_wr ? '0 : cur_off;
    key_ok   = eff_key != KEY_INVALID;
    in_range = key_ok && (eff_off < item_len);
    rd_ready = !out_valid || out_ready;
    rd_fire  = rd_valid && rd_ready;
    wr_take  = wr_valid && !rd_valid && eff_key[WCH_BIT] && in_range;
    off_inc  = eff_off + LEN_W'(1);
    fill_end = off_inc == item_len;
    if (rd_fire && in_range)  next_off = off_inc;
    else if (wr_take)         next_off = fill_end ? '0 : off_inc;
    else                      next_off = eff_off;
    wr_en    = wr_take;
    wr_byte  = wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_key    <= '0;
      cur_off    <= '0;
      out_valid  <= 1'b0;
      out_data   <= 8'h00;
      done_pulse <= 1'b0;
      done_bank  <= 1'b0;
      done_entry <= '0;
    end else begin
      cur_key    <= eff_key;
      cur_off    <= next_off;
      done_pulse <= wr_take && fill_end;
      if (wr_take) begin
        done_bank  <= eff_key[ARCH_BIT];
        done_entry <= eff_key[IDX_W-1:0];
      end
      if (rd_fire) begin
        out_valid <= 1'b1;
        out_data  <= in_range ? rd_byte : 8'h00;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cfgp_port.sv
module cfgp_port #(
  parameter int ENTRIES = 16,
  parameter int MAX_LEN = 16,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int OFF_IDX_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_wr,
  input  logic [15:0]      sel_key,
  input  logic             rd_valid,
  output logic             rd_ready,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  output logic             out_valid,
  output logic [7:0]       out_data,
  input  logic             out_ready,
  output logic             done_pulse,
  output logic             done_bank,
  output logic [IDX_W-1:0] done_entry
);
  import cfgp_pkg::*;

  logic [KEY_W-1:0] norm_key, eff_key, cur_key;
  logic [LEN_W-1:0] eff_off, cur_off, item_len;
  logic [7:0]       rd_byte, wr_byte;
  logic             wr_en;

  cfgp_key_decode #(.ENTRIES(ENTRIES)) u_dec (
    .key_in (sel_key),
    .key_out(norm_key)
  );

  cfgp_seq #(.ENTRIES(ENTRIES)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .sel_wr(sel_wr), .norm_key(norm_key),
    .rd_valid(rd_valid), .rd_ready(rd_ready),
    .wr_valid(wr_valid), .wr_data(wr_data),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .rd_byte(rd_byte), .item_len(item_len),
    .eff_key(eff_key), .eff_off(eff_off),
    .wr_en(wr_en), .wr_byte(wr_byte),
    .done_pulse(done_pulse), .done_bank(done_bank), .done_entry(done_entry),
    .cur_key(cur_key), .cur_off(cur_off)
  );

  cfgp_item_store #(.ENTRIES(ENTRIES), .MAX_LEN(MAX_LEN)) u_store (
    .clk(clk), .rst_n(rst_n),
    .bank(eff_key[ARCH_BIT]),
    .entry(eff_key[IDX_W-1:0]),
    .off(eff_off[OFF_IDX_W-1:0]),
    .wr_en(wr_en), .wr_byte(wr_byte),
    .rd_byte(rd_byte), .len(item_len)
  );
endmodule

// File: rtl/cfgp_port_checker.sv
module cfgp_port_checker #(
  parameter int ENTRIES = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        sel_wr,
  input logic [15:0] sel_key,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic        wr_valid,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_data,
  input logic        done_pulse,
  input logic [15:0] cur_key,
  input logic [15:0] cur_off
);
  a_r1_select_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr && !rd_valid && !wr_valid |=> cur_off == 16'd0);

  a_r2_bad_index: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr && (sel_key[13:0] >= 14'(ENTRIES)) |=> cur_key == 16'hFFFF);

  a_r5_invalid_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready && !sel_wr && cur_key == 16'hFFFF
    |=> out_data == 8'h00 && cur_off == $past(cur_off));

  a_r7_pulse_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> $past(wr_valid && !rd_valid) && cur_off == 16'd0);

  a_r12_no_ready_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !rd_ready);

  a_r12_hold_response: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

bind cfgp_port cfgp_port_checker #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_key(sel_key),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .wr_valid(wr_valid),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .done_pulse(done_pulse), .cur_key(cur_key), .cur_off(cur_off)
);

// File: tb/cfgp_port_test.sv
`timescale 1ns/1ps
module cfgp_port_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, sel_wr, rd_valid, rd_ready, wr_valid, out_valid, out_ready;
  logic done_pulse, done_bank;
  logic [15:0] sel_key;
  logic [7:0] wr_data, out_data;
  logic [3:0] done_entry;

  cfgp_port uut (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_key(sel_key),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .wr_valid(wr_valid), .wr_data(wr_data),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .done_pulse(done_pulse), .done_bank(done_bank), .done_entry(done_entry)
  );

  int nchecks = 0, nfail = 0;
  logic [7:0] mmem [2][16][16];
  logic [15:0] mkey, moff;

  function automatic int m_len(input logic b, input int e);
    if (!b) case (e) 0: return 4; 1: return 2; 2: return 4; 3: return 3; 4: return 16; default: return 0; endcase
    case (e) 0: return 2; 1: return 5; default: return 0; endcase
  endfunction

  function automatic logic [7:0] m_init(input logic b, input int e, input int i);
    logic [7:0] sig [4];
    sig = '{8'h43, 8'h46, 8'h47, 8'h50};
    if (!b && e == 0 && i < 4) return sig[i];
    if (!b && e == 1 && i < 2) return (i == 0) ? 8'h34 : 8'h12;
    if (!b && e == 2 && i < 4) return 8'hD4 - 8'(i * 8'h11);
    if (!b && e == 4) return 8'(8'h40 + i);
    if (b && e == 0 && i < 2) return (i == 0) ? 8'hEF : 8'hBE;
    return 8'h00;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic [15:0] k, input logic r, input logic w,
                      input logic [7:0] d, input string req);
    logic [7:0] exp_b;
    logic exp_done, ok;
    int len;
    if (s) begin
      mkey = (k[13:0] >= 14'd16) ? 16'hFFFF : k;
      moff = 0;
    end
    ok = mkey != 16'hFFFF;
    len = ok ? m_len(mkey[15], int'(mkey[3:0])) : 0;
    exp_b = 8'h00;
    exp_done = 1'b0;
    if (r) begin
      if (int'(moff) < len) begin
        exp_b = mmem[mkey[15]][mkey[3:0]][moff[3:0]];
        moff++;
      end
    end else if (w && ok && mkey[14] && int'(moff) < len) begin
      mmem[mkey[15]][mkey[3:0]][moff[3:0]] = d;
      moff++;
      if (int'(moff) == len) begin
        exp_done = 1'b1;
        moff = 0;
      end
    end
    sel_wr = s; sel_key = k; rd_valid = r; wr_valid = w; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    sel_wr = 0; rd_valid = 0; wr_valid = 0;
    chk(out_valid == r, {req, " out_valid"}, out_valid, r);
    if (r) chk(out_data == exp_b, {req, " out_data"}, out_data, exp_b);
    chk(done_pulse == exp_done, {req, " done_pulse"}, done_pulse, exp_done);
    if (exp_done) chk({done_bank, done_entry} == {mkey[15], mkey[3:0]},
                      {req, " done item"}, {done_bank, done_entry}, {mkey[15], mkey[3:0]});
  endtask

  initial begin
    #(200000 * 5);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    for (int b = 0; b < 2; b++)
      for (int e = 0; e < 16; e++)
        for (int i = 0; i < 16; i++) mmem[b][e][i] = m_init(b == 1, e, i);
    mkey = 0; moff = 0;
    rst_n = 0; sel_wr = 0; sel_key = 0; rd_valid = 0; wr_valid = 0; wr_data = 0; out_ready = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R8: reset state
    chk(out_valid == 0, "R8 out_valid after reset", out_valid, 0);
    chk(done_pulse == 0, "R8 done after reset", done_pulse, 0);
    chk(rd_ready == 1, "R8 rd_ready after reset", rd_ready, 1);
    // R8 R9: key 0 selected by reset, signature bytes
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0, "R8 R9 signature");
    step(0, 0, 1, 0, 0, "R5 past end");
    step(1, 16'h0001, 0, 0, 0, "R1");
    step(0, 0, 1, 0, 0, "R9 16-bit lsb");
    step(0, 0, 1, 0, 0, "R9 16-bit msb");
    step(1, 16'h0002, 0, 0, 0, "R1");
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0, "R4 R9 32-bit");
    step(1, 16'h8000, 0, 0, 0, "R3");
    step(0, 0, 1, 0, 0, "R3 local bank");
    step(0, 0, 1, 0, 0, "R3 local bank");
    step(1, 16'h0010, 0, 0, 0, "R2");
    step(0, 0, 1, 0, 0, "R2 R5 index 16 invalid");
    step(1, 16'h3FFF, 1, 0, 0, "R2 R5 R10 invalid");
    step(1, 16'h0005, 0, 0, 0, "R1");
    step(0, 0, 1, 0, 0, "R5 length zero");
    // R6: write without write-access bit is ignored
    step(1, 16'h0003, 0, 1, 8'h55, "R6 R10 no access bit");
    step(1, 16'h0003, 1, 0, 0, "R6 ignored write readback");
    // R7: fill writable item
    step(1, 16'h4003, 0, 0, 0, "R1");
    step(0, 0, 0, 1, 8'hAA, "R6");
    step(0, 0, 0, 1, 8'hBB, "R6");
    step(0, 0, 0, 1, 8'hCC, "R7 completion");
    step(0, 0, 0, 1, 8'hDD, "R7 rewound offset");
    step(1, 16'h0003, 1, 0, 0, "R6 R10 readback");
    step(0, 0, 1, 0, 0, "R6 readback");
    step(0, 0, 1, 0, 0, "R6 readback");
    // R7 local bank completion
    step(1, 16'hC001, 0, 1, 8'h01, "R10 select with write");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 8'(8'h02 + i), "R7 local");
    // R11: read and write together
    step(1, 16'h4003, 0, 0, 0, "R1");
    step(0, 0, 1, 1, 8'h99, "R11 collision");
    step(1, 16'h0003, 1, 0, 0, "R11 write dropped");
    step(0, 0, 1, 0, 0, "R11 write dropped");
    // R12: back-pressure
    step(1, 16'h0004, 0, 0, 0, "R1");
    out_ready = 0; rd_valid = 1;
    @(posedge clk); @(negedge clk);
    chk(out_valid == 1 && out_data == 8'h40, "R12 first response", out_data, 8'h40);
    chk(rd_ready == 0, "R12 rd_ready low", rd_ready, 0);
    @(posedge clk); @(negedge clk);
    chk(out_valid == 1 && out_data == 8'h40, "R12 response held", out_data, 8'h40);
    rd_valid = 0; out_ready = 1;
    @(posedge clk); @(negedge clk);
    chk(out_valid == 0, "R12 drained", out_valid, 0);
    moff = 1;
    step(0, 0, 1, 0, 0, "R12 stalled request not performed");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] k;
      logic s, r, w;
      int p;
      p = $urandom_range(0, 99);
      k = {1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 10'd0, 4'($urandom_range(0, 5))};
      if ($urandom_range(0, 9) == 0) k = ($urandom_range(0, 1) == 1) ? 16'hFFFF : 16'(16 + $urandom_range(0, 500));
      s = p < 15;
      r = (p >= 10 && p < 55) || (p >= 90);
      w = p >= 55;
      step(s, k, r, w, 8'($urandom), "R4 R5 R6 R7 R10 R11 random");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule